// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver with Early Start-Edge Hunting

This block turns an asynchronous serial line into bytes. Each character has a low start bit, eight data bits sent least significant bit first, no parity and one high stop bit. The line rests high. The line passes through a synchronizer and is sampled sixteen times per bit period. Each received byte appears on a data output with a valid strobe one clock long. A stop bit that reads low gives a framing-error strobe instead of the valid strobe.

The receiver takes the stop-bit sample at its estimate of the bit's middle. It starts looking for the next falling edge straight after that sample, and it does not wait for the stop bit's nominal end. Every start edge realigns the bit timing. An unbroken stream can therefore run for any length without slipping, whether the sending clock is a little fast or a little slow. Two level flags report the line state. The idle flag means the line has stayed high for more than eleven bit times. The break flag means it has stayed low for at least eleven bit times. When a character of all zeros also has a low stop bit, reception is held off until the line goes high again, so a break yields a single framing error and no run of false characters.

The controller has five states. `RX_HUNT` waits on each oversample tick for a low line and moves to `RX_START`. `RX_START` counts half a bit. If the line is still low it moves to `RX_DATA`; otherwise it returns to `RX_HUNT`. `RX_DATA` samples eight bits at their middles and then moves to `RX_STOP`. `RX_STOP` samples the stop bit. If it is high, the state goes back to `RX_HUNT` with a valid strobe. If it is low, the state goes to `RX_BLOCK` when every data bit was zero, and back to `RX_HUNT` otherwise, with a framing-error strobe in both cases. `RX_BLOCK` returns to `RX_HUNT` once the synchronized line is high.

Top module: `uart_rx_resync`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, the outputs read as follows: data_o is 0x00, and valid_o, ferr_o, idle_o and brk_o are all 0.
- R2: A character sent at the nominal rate (16 × CLKS_PER_TICK clocks per bit) appears on data_o. Bit 0 of the byte is the first data bit after the start bit. valid_o goes high for exactly one clock.
- R3: A low pulse shorter than half a bit is not taken as a start bit. It gives no valid_o and no ferr_o.
- R4: A back-to-back stream with no gaps, sent about 3 % faster than nominal, is received with every byte correct and in order.
- R5: A back-to-back stream with no gaps, sent about 3 % slower than nominal, is received with every byte correct and in order.
- R6: A character whose stop bit reads low gives a one-clock ferr_o and no valid_o. The next character is received normally.
- R7: A line held low for many character times gives exactly one ferr_o and no valid_o. Once the line returns high, the next character is received normally.
- R8: idle_o is 1 after the line has been high for 12 bit times and 0 after 10 bit times. It drops once the line goes low.
- R9: brk_o is 1 after the line has been low for 12 bit times and 0 after 10 bit times. It drops within a few clocks after the line goes high.
- R10: A stop bit that lasts only about 0.7 of a bit, followed at once by the next start edge, still lets both characters be received. This shows that hunting starts right after the mid-stop sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Raw asynchronous serial line; high when idle |
| data_o | output | 8 | Last byte received correctly; held between strobes |
| valid_o | output | 1 | One-clock strobe for a new byte on data_o |
| ferr_o | output | 1 | One-clock strobe for a character whose stop bit read low |
| idle_o | output | 1 | Line has been high for more than 11 bit times |
| brk_o | output | 1 | Line has been low for at least 11 bit times |

## Verification
The main path is driven with four kinds of pattern. Isolated characters at the nominal rate with varied bit patterns show that the bit order and the sampling points are right. Gap-free streams 3 % fast and 3 % slow show whether any error builds up from one character to the next. A shortened stop bit tells early hunting apart from hunting at the end of the stop bit. Low stop bits, a short glitch and a long break each show a different response: a framing strobe and then recovery, a rejected false start, and a single error that holds reception off. The idle and break flags are probed on both sides of the eleven-bit threshold.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;
    typedef enum logic [2:0] {
        RX_HUNT  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_STOP  = 3'd3,
        RX_BLOCK = 3'd4
    } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
`timescale 1ns/1ps
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_tick.sv
`timescale 1ns/1ps
module uart_rx_tick #(
    parameter int CLKS_PER_TICK = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (CLKS_PER_TICK <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(CLKS_PER_TICK);
            localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);
            logic [CW-1:0] div_q;

            always_ff @(posedge clk) begin
                if (!rst_n)             div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                    div_q <= div_q + 1'b1;
            end

            assign tick_o = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/uart_rx_linemon.sv
`timescale 1ns/1ps
module uart_rx_linemon #(
    parameter int GAP_TICKS = 176
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic line_i,
    output logic idle_o,
    output logic brk_o
);
    localparam int RUN_W = $clog2(GAP_TICKS + 2);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(GAP_TICKS + 1);
    localparam logic [RUN_W-1:0] RUN_GAP = RUN_W'(GAP_TICKS);

    logic             lvl_q;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b1;
            run_q <= '0;
        end else if (line_i != lvl_q) begin
            lvl_q <= line_i;
            run_q <= '0;
        end else if (tick_i && run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign idle_o = lvl_q && (run_q > RUN_GAP);
    assign brk_o  = !lvl_q && (run_q >= RUN_GAP);

    assert_idle_rise_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_o) |-> $past(line_i));
    assert_brk_rise_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_o) |-> !$past(line_i));
    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle_o && brk_o));
endmodule

// File: rtl/uart_rx_resync.sv
`timescale 1ns/1ps
module uart_rx_resync
    import uart_rx_pkg::*;
#(
    parameter int CLKS_PER_TICK = 4,
    parameter int OVERSAMPLE    = 16,
    parameter int DATA_BITS     = 8,
    parameter int GAP_BITS      = 11,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 ferr_o,
    output logic                 idle_o,
    output logic                 brk_o
);
    localparam int SCNT_W    = $clog2(OVERSAMPLE);
    localparam int BIT_W     = $clog2(DATA_BITS);
    localparam int GAP_TICKS = GAP_BITS * OVERSAMPLE;
    localparam logic [SCNT_W-1:0] SC_HALF = SCNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [SCNT_W-1:0] SC_LAST = SCNT_W'(OVERSAMPLE - 1);
    localparam logic [BIT_W-1:0]  BI_LAST = BIT_W'(DATA_BITS - 1);

    logic rx_s;
    logic tick;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
    );

    uart_rx_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    uart_rx_linemon #(.GAP_TICKS(GAP_TICKS)) u_mon (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .line_i(rx_s),
        .idle_o(idle_o), .brk_o(brk_o)
    );

    rx_state_e            st_q, st_d;
    logic [SCNT_W-1:0]    scnt_q, scnt_d;
    logic [BIT_W-1:0]     bit_q, bit_d;
    logic [DATA_BITS-1:0] sh_q, sh_d;
    logic                 ok_ev, bad_ev;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RX_HUNT;
            scnt_q <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
        end else begin
            st_q   <= st_d;
            scnt_q <= scnt_d;
            bit_q  <= bit_d;
            sh_q   <= sh_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d   = st_q;
        scnt_d = scnt_q;
        bit_d  = bit_q;
        sh_d   = sh_q;
        ok_ev  = 1'b0;
        bad_ev = 1'b0;
        unique case (st_q)
            RX_HUNT: begin
                if (tick && !rx_s) begin
                    st_d   = RX_START;
                    scnt_d = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (scnt_q == SC_HALF) begin
                        scnt_d = '0;
                        if (!rx_s) begin
                            st_d  = RX_DATA;
                            bit_d = '0;
                        end else begin
                            st_d = RX_HUNT;
                        end
                    end else begin
                        scnt_d = scnt_q + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (scnt_q == SC_LAST) begin
                        scnt_d = '0;
                        sh_d   = {rx_s, sh_q[DATA_BITS-1:1]};
                        if (bit_q == BI_LAST) st_d = RX_STOP;
                        else                  bit_d = bit_q + 1'b1;
                    end else begin
                        scnt_d = scnt_q + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (scnt_q == SC_LAST) begin
                        scnt_d = '0;
                        if (rx_s) begin
                            ok_ev = 1'b1;
                            st_d  = RX_HUNT;
                        end else begin
                            bad_ev = 1'b1;
                            st_d   = (sh_q == '0) ? RX_BLOCK : RX_HUNT;
                        end
                    end else begin
                        scnt_d = scnt_q + 1'b1;
                    end
                end
            end
            RX_BLOCK: begin
                if (rx_s) st_d = RX_HUNT;
            end
            default: st_d = RX_HUNT;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= ok_ev;
            ferr_o  <= bad_ev;
            if (ok_ev) data_o <= sh_q;
        end
    end

    assert_valid_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    assert_valid_after_high_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(rx_s));
    assert_valid_ferr_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && ferr_o));
    assert_no_char_in_break_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |-> !valid_o);
    assert_data_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o));
endmodule

// File: tb/tb_uart_rx_resync.sv
`timescale 1ns/1ps
module tb_uart_rx_resync;
    localparam int NOM = 64;  // clocks per bit at CLKS_PER_TICK=4, 16x oversample
    localparam int NV  = 16;
    // {bad_stop, data, bit_clks, stop_clks, gap_clks}
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'h55, 8'd64, 8'd64, 8'd64},
        {1'b0, 8'hA3, 8'd64, 8'd64, 8'd64},
        {1'b0, 8'h01, 8'd64, 8'd64, 8'd64},
        {1'b0, 8'h80, 8'd64, 8'd64, 8'd64},
        {1'b0, 8'hFF, 8'd64, 8'd64, 8'd64},
        {1'b0, 8'h00, 8'd64, 8'd64, 8'd200},
        {1'b0, 8'h3C, 8'd62, 8'd62, 8'd0},
        {1'b0, 8'hC3, 8'd62, 8'd62, 8'd0},
        {1'b0, 8'h5A, 8'd66, 8'd66, 8'd0},
        {1'b0, 8'h96, 8'd66, 8'd66, 8'd200},
        {1'b0, 8'h12, 8'd64, 8'd44, 8'd0},
        {1'b0, 8'h34, 8'd64, 8'd44, 8'd0},
        {1'b0, 8'hED, 8'd64, 8'd44, 8'd100},
        {1'b1, 8'h6D, 8'd64, 8'd40, 8'd200},
        {1'b0, 8'h77, 8'd64, 8'd64, 8'd200},
        {1'b1, 8'hB2, 8'd64, 8'd40, 8'd200}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic [7:0] data_o;
    logic       valid_o, ferr_o, idle_o, brk_o;

    uart_rx_resync dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .data_o(data_o),
        .valid_o(valid_o), .ferr_o(ferr_o), .idle_o(idle_o), .brk_o(brk_o)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic [7:0] cap [256];
    int cap_n = 0;
    int ferr_n = 0;
    int vlen = 0;
    logic prev_valid = 1'b0;
    int multi_valid = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o) begin
                if (cap_n < 256) cap[cap_n] = data_o;
                cap_n++;
            end
            if (ferr_o) ferr_n++;
            if (valid_o && prev_valid) multi_valid++;
            prev_valid = valid_o;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx = lvl;
        end
    endtask

    task automatic send(input logic [7:0] d, input int bitc, input int stopc, input bit bad);
        hold(1'b0, bitc);
        for (int b = 0; b < 8; b++) hold(d[b], bitc);
        hold(bad ? 1'b0 : 1'b1, stopc);
        if (bad) hold(1'b1, 1);
    endtask

    initial begin
        int exp_n;
        int f0;
        int c0;
        logic [7:0] exp_b [64];
        // R1: reset state
        repeat (5) @(negedge clk);
        chk("R1 data", data_o, 0);
        chk("R1 valid", valid_o, 0);
        chk("R1 ferr", ferr_o, 0);
        chk("R1 idle", idle_o, 0);
        chk("R1 brk", brk_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after release", valid_o, 0);
        chk("R1 brk after release", brk_o, 0);
        hold(1'b1, 3 * NOM);

        // Table walk: R2, R4, R5, R6, R10
        exp_n = 0;
        for (int v = 0; v < NV; v++) begin
            send(VEC[v][31:24], int'(VEC[v][23:16]), int'(VEC[v][15:8]), VEC[v][32]);
            hold(1'b1, int'(VEC[v][7:0]));
            if (!VEC[v][32]) begin
                exp_b[exp_n] = VEC[v][31:24];
                exp_n++;
            end
        end
        hold(1'b1, 4 * NOM);
        chk("R2 table byte count", cap_n, exp_n);
        chk("R6 table framing count", ferr_n, 2);
        for (int k = 0; k < exp_n; k++) begin
            string tg;
            if (k >= 6 && k <= 7)       tg = "R4 fast pair";
            else if (k >= 8 && k <= 9)  tg = "R5 slow pair";
            else if (k >= 10 && k <= 12) tg = "R10 short stop";
            else if (k == 13)           tg = "R6 after framing";
            else                        tg = "R2 nominal";
            chk(tg, cap[k], exp_b[k]);
        end
        chk("R2 single-cycle strobe", multi_valid, 0);

        // R4: long gap-free fast stream
        c0 = cap_n;
        for (int i = 0; i < 32; i++) send(8'((i * 37 + 11) & 255), 62, 62, 1'b0);
        hold(1'b1, 4 * NOM);
        chk("R4 stream count", cap_n - c0, 32);
        for (int i = 0; i < 32; i++) chk("R4 stream byte", cap[c0 + i], (i * 37 + 11) & 255);

        // R5: long gap-free slow stream
        c0 = cap_n;
        for (int i = 0; i < 32; i++) send(8'((i * 53 + 7) & 255), 66, 66, 1'b0);
        hold(1'b1, 4 * NOM);
        chk("R5 stream count", cap_n - c0, 32);
        for (int i = 0; i < 32; i++) chk("R5 stream byte", cap[c0 + i], (i * 53 + 7) & 255);

        // R3: short glitch ignored
        c0 = cap_n;
        f0 = ferr_n;
        hold(1'b0, 20);
        hold(1'b1, 20 * NOM);
        chk("R3 glitch no byte", cap_n - c0, 0);
        chk("R3 glitch no framing", ferr_n - f0, 0);

        // R8: idle flag threshold after an 0xFF character
        send(8'hFF, NOM, NOM, 1'b0);
        hold(1'b1, NOM);            // line high 10 bit times since start bit ended
        @(negedge clk);
        chk("R8 idle below threshold", idle_o, 0);
        hold(1'b1, 2 * NOM);        // 12 bit times
        chk("R8 idle above threshold", idle_o, 1);

        // R9 / R7: break
        c0 = cap_n;
        f0 = ferr_n;
        hold(1'b0, 10 * NOM);
        chk("R8 idle drops on low", idle_o, 0);
        chk("R9 brk below threshold", brk_o, 0);
        hold(1'b0, 2 * NOM);
        chk("R9 brk above threshold", brk_o, 1);
        hold(1'b0, 18 * NOM);
        chk("R9 brk held", brk_o, 1);
        hold(1'b1, 10);
        chk("R9 brk clears", brk_o, 0);
        hold(1'b1, 4 * NOM);
        chk("R7 one framing error", ferr_n - f0, 1);
        chk("R7 no byte in break", cap_n - c0, 0);
        send(8'hC9, NOM, NOM, 1'b0);
        hold(1'b1, 2 * NOM);
        chk("R7 byte count after break", cap_n - c0, 1);
        chk("R7 byte after break", cap[c0], 8'hC9);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule